// File: doc/BRIEF.md
# SDRAM Single-Bank Read Sequencer with Auto-Precharge

This block turns one read request into the full command sequence a 16-bit synchronous DRAM needs to return a four-word burst from one bank. A request carries a bank, a row and a column and is taken through a valid/ready handshake. The sequencer opens the row with an ACTIVE command and waits out the row-to-column delay. It then issues a READ with the auto-precharge address bit raised, so the DRAM closes the row by itself. The sequencer samples the four returned words after a CAS latency of two clocks and delivers them on a registered stream with a valid strobe and a last-beat flag.

No explicit PRECHARGE is ever sent. The sequencer therefore models the start of the internal precharge itself. That start is the later of ACTIVE plus the minimum row-active time and READ plus the burst length. The next ACTIVE is held back until both the row-cycle time from the previous ACTIVE and the precharge time from that modelled start have passed. All timing values are given in nanoseconds and are rounded up to whole clocks of the configurable clock period. With the defaults (8 ns clock, 18/42/60/18 ns) this gives 3, 6, 8 and 3 cycles.

Top module: `sdram_rdseq`

## Requirements
- R1: After reset the command pins {cs_n, ras_n, cas_n, we_n} read 0111 (NOP), req_ready is high, rd_valid is low and both byte masks are high. With no request pending, only NOP is driven.
- R2: In the cycle after a request is accepted, the command is ACTIVE (0011), with the request row on sd_addr and the request bank on sd_ba.
- R3: READ (0101) appears exactly TRCD cycles (3 by default) after the ACTIVE cycle.
- R4: During READ, sd_addr bit 10 is high, sd_addr[7:0] carries the column, and bits 9:8 are zero.
- R5: The word on sd_dq at the second rising edge after the edge that samples READ is the first word of the burst, and the next three words follow on the next three edges. rd_data presents these words in the order they arrived, with rd_valid high in the cycles READ+3 through READ+6.
- R6: Two ACTIVE commands are at least 10 cycles apart by default. The spacing is max(tRC, P + tRP), where P = max(ACTIVE + tRAS, READ + 4) is the modelled start of the internal precharge.
- R7: req_ready is low from the cycle of ACTIVE until exactly 9 cycles after it (default timings), and it returns high in that cycle.
- R8: rd_valid is high for exactly four consecutive cycles per request, and rd_last is high only with the fourth word.
- R9: Both byte masks are driven low from the READ cycle until the cycle after the last beat is presented, and are high otherwise, including in every ACTIVE cycle.
- R10: A request raised while req_ready is low is held off, not dropped. It is accepted as soon as req_ready rises, so back-to-back requests give ACTIVE commands exactly 10 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| req_bank | input | BANK_W (1) | Bank of the request |
| req_row | input | ROW_W (11) | Row of the request |
| req_col | input | COL_W (8) | Starting column of the burst |
| rd_data | output | DQ_W (16) | Registered burst word |
| rd_valid | output | 1 | rd_data holds a burst word |
| rd_last | output | 1 | Fourth and final word of the burst |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W (11) | Multiplexed row/column address, bit 10 = auto-precharge on READ |
| sd_ba | output | BANK_W (1) | Bank address |
| sd_dqm | output | DQ_W/8 (2) | Byte masks, bit 0 lower byte, bit 1 upper byte |
| sd_dq | input | DQ_W (16) | Data from the DRAM |

## Verification
Two functions meet in one cycle with back-to-back requests: the last beat of one burst (rd_last) is presented in the same cycle that req_ready rises for the next request. A held request is then accepted on the very next edge. The bench provokes this by keeping req_valid high from the moment the previous request is taken. It judges the overlap by checking that the final word and its last flag are correct, that the next ACTIVE is exactly 10 cycles after the previous one, and that the byte masks are already high again in that ACTIVE cycle. A behavioural responder returns address-derived words with a latency of two clocks, including columns that wrap within a group of four.

// File: rtl/sdram_rdseq_pkg.sv
package sdram_rdseq_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BURST
    } seq_state_e;

    // Timer slots
    localparam int TI_RCD = 0;
    localparam int TI_RAS = 1;
    localparam int TI_RC  = 2;
    localparam int TI_BL  = 3;
    localparam int TI_RP  = 4;
    localparam int N_TMR  = 5;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_rdseq_tmr.sv
module sdram_rdseq_tmr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Loaded with N, reaches zero N-1 cycles after the load edge
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_rdseq_cap.sv
module sdram_rdseq_cap #(
    parameter int DQ_W = 16,
    parameter int CL   = 2,
    parameter int BL   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_issued,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] data,
    output logic            valid,
    output logic            last
);
    localparam int CW = $clog2(BL + 1);

    logic [CL-1:0] hit;
    logic [CW-1:0] left;
    logic          take;
    logic          final_beat;

    assign take       = hit[CL-1] || (left != '0);
    assign final_beat = hit[CL-1] ? (BL == 1) : (left == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hit   <= '0;
            left  <= '0;
            data  <= '0;
            valid <= 1'b0;
            last  <= 1'b0;
        end else begin
            hit <= (hit << 1) | CL'(rd_issued);
            if (hit[CL-1])
                left <= CW'(BL - 1);
            else if (left != '0)
                left <= left - CW'(1);
            if (take)
                data <= dq_in;
            valid <= take;
            last  <= take && final_beat;
        end
    end
endmodule

// File: rtl/sdram_rdseq.sv
module sdram_rdseq
    import sdram_rdseq_pkg::*;
#(
    parameter int CLK_NS  = 8,
    parameter int TRCD_NS = 18,
    parameter int TRAS_NS = 42,
    parameter int TRC_NS  = 60,
    parameter int TRP_NS  = 18,
    parameter int CL      = 2,
    parameter int BL      = 4,
    parameter int BANK_W  = 1,
    parameter int ROW_W   = 11,
    parameter int COL_W   = 8,
    parameter int AP_BIT  = 10,
    parameter int DQ_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [DQ_W/8-1:0] sd_dqm,
    input  logic [DQ_W-1:0]   sd_dq
);
    localparam int TRCD_C = ns_to_cyc(TRCD_NS, CLK_NS);
    localparam int TRAS_C = ns_to_cyc(TRAS_NS, CLK_NS);
    localparam int TRC_C  = ns_to_cyc(TRC_NS, CLK_NS);
    localparam int TRP_C  = ns_to_cyc(TRP_NS, CLK_NS);
    localparam int PRE_C  = imax(TRAS_C, TRCD_C + BL);
    localparam int GAP_C  = imax(TRC_C, PRE_C + TRP_C);
    localparam int TW     = $clog2(GAP_C + 1) + 1;
    localparam int MW     = DQ_W / 8;

    seq_state_e        st;
    sd_cmd_e           cmd_q;
    logic [ROW_W-1:0]  addr_q;
    logic [BANK_W-1:0] ba_q;
    logic [COL_W-1:0]  col_q;
    logic [MW-1:0]     dqm_q;
    logic [ROW_W-1:0]  rd_addr;

    logic [N_TMR-1:0]  t_load;
    logic [N_TMR-1:0]  t_zero;
    logic [TW-1:0]     t_val [N_TMR];

    logic accept, go_read, close_row;

    assign req_ready = (st == ST_IDLE) && t_zero[TI_RC] && t_zero[TI_RP];
    assign accept    = req_valid && req_ready;
    assign go_read   = (st == ST_OPEN) && t_zero[TI_RCD];
    assign close_row = (st == ST_BURST) && t_zero[TI_RAS] && t_zero[TI_BL];

    assign t_val[TI_RCD] = TW'(TRCD_C);
    assign t_val[TI_RAS] = TW'(TRAS_C);
    assign t_val[TI_RC]  = TW'(TRC_C);
    assign t_val[TI_BL]  = TW'(BL);
    assign t_val[TI_RP]  = TW'(TRP_C);

    assign t_load[TI_RCD] = accept;
    assign t_load[TI_RAS] = accept;
    assign t_load[TI_RC]  = accept;
    assign t_load[TI_BL]  = go_read;
    assign t_load[TI_RP]  = close_row;

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        sdram_rdseq_tmr #(.W(TW)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .load (t_load[i]),
            .val  (t_val[i]),
            .zero (t_zero[i])
        );
    end

    always_comb begin
        rd_addr                = '0;
        rd_addr[COL_W-1:0]     = col_q;
        rd_addr[AP_BIT]        = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
            col_q  <= '0;
            dqm_q  <= '1;
        end else begin
            cmd_q <= CMD_NOP;
            if (rd_last)
                dqm_q <= '1;
            unique case (st)
                ST_IDLE: if (accept) begin
                    cmd_q  <= CMD_ACT;
                    addr_q <= req_row;
                    ba_q   <= req_bank;
                    col_q  <= req_col;
                    st     <= ST_OPEN;
                end
                ST_OPEN: if (go_read) begin
                    cmd_q  <= CMD_RD;
                    addr_q <= rd_addr;
                    dqm_q  <= '0;
                    st     <= ST_BURST;
                end
                ST_BURST: if (close_row)
                    st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    sdram_rdseq_cap #(.DQ_W(DQ_W), .CL(CL), .BL(BL)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rd_issued (cmd_q == CMD_RD),
        .dq_in     (sd_dq),
        .data      (rd_data),
        .valid     (rd_valid),
        .last      (rd_last)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_addr = addr_q;
    assign sd_ba   = ba_q;
    assign sd_dqm  = dqm_q;
endmodule

// File: rtl/sdram_rdseq_chk.sv
module sdram_rdseq_chk #(
    parameter int TRCD_C = 3,
    parameter int GAP_C  = 10,
    parameter int AP_BIT = 10,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic              ready,
    input logic              valid,
    input logic              last
);
    localparam int SW = $clog2(GAP_C + 1) + 2;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0] since_act;
    logic          seen_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '0;
            seen_act  <= 1'b0;
        end else if (cmd == 4'b0011) begin
            since_act <= SW'(1);
            seen_act  <= 1'b1;
        end else if (since_act != SMAX) begin
            since_act <= since_act + SW'(1);
        end
    end

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0111) || (cmd == 4'b0011) || (cmd == 4'b0101)); // R1

    AST_READ_AFTER_RCD: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0101) |-> (seen_act && since_act == SW'(TRCD_C))); // R3

    AST_AP_BIT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0101) |-> addr[AP_BIT]); // R4

    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0011 && seen_act) |-> (since_act >= SW'(GAP_C))); // R6

    AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
        (ready && seen_act) |-> (since_act >= SW'(GAP_C - 1))); // R7

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        last |-> valid); // R8

    AST_VALID_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(valid) |-> $past(last)); // R8
endmodule

bind sdram_rdseq sdram_rdseq_chk #(
    .TRCD_C (TRCD_C),
    .GAP_C  (GAP_C),
    .AP_BIT (AP_BIT),
    .ADDR_W (ROW_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cmd   ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .addr  (sd_addr),
    .ready (req_ready),
    .valid (rd_valid),
    .last  (rd_last)
);

// File: tb/tb_sdram_rdseq.sv
module tb_sdram_rdseq;
    localparam int CLK_PERIOD = 8;
    localparam int NV = 6;
    localparam int RCD = 3, GAP = 10, RDY = 9, FIRST = 3, CLAT = 2, BLEN = 4;

    // {gap[3:0], bank, row[10:0], col[7:0]}; gap 0 = raised while busy
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 1'b0, 11'h123, 8'h10},
        {4'd0, 1'b1, 11'h7FF, 8'hFE},
        {4'd0, 1'b0, 11'h000, 8'h03},
        {4'd5, 1'b1, 11'h2AA, 8'h81},
        {4'd0, 1'b0, 11'h555, 8'hFF},
        {4'd1, 1'b1, 11'h400, 8'h00}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [0:0] req_bank = '0;
    logic [10:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic [15:0] rd_data;
    logic rd_valid, rd_last;
    logic cs_n, ras_n, cas_n, we_n;
    logic [10:0] sd_addr;
    logic [0:0] sd_ba;
    logic [1:0] sd_dqm;
    logic [15:0] sd_dq = 16'hDEAD;

    sdram_rdseq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
        .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .sd_dq(sd_dq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    function automatic logic [15:0] pat(input logic b, input logic [10:0] r, input logic [7:0] c);
        return {b, r[6:0], c} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    // Behavioural DRAM: latency 2, sequential burst wrapping within 4
    logic [10:0] open_row [2];
    int rk = 0;
    logic [7:0] rcol;
    logic rbank;
    always @(posedge clk) begin
        if (cmd == 4'b0011) open_row[sd_ba] <= sd_addr;
        if (cmd == 4'b0101) begin
            rk <= 1; rcol <= sd_addr[7:0]; rbank <= sd_ba;
        end else if (rk != 0) begin
            rk <= (rk == CLAT - 1 + BLEN) ? 0 : rk + 1;
        end
        if (rk >= CLAT - 1 && rk < CLAT - 1 + BLEN)
            sd_dq <= pat(rbank, open_row[rbank],
                         {rcol[7:2], 2'(rcol[1:0] + 2'(rk - (CLAT - 1)))});
        else
            sd_dq <= 16'hDEAD;
    end

    // Expected request record, filled by the driver
    logic        ex_bank [NV];
    logic [10:0] ex_row  [NV];
    logic [7:0]  ex_col  [NV];
    bit          ex_held [NV];
    int n_sent = 0;

    int act_n = 0, rd_n = 0, beat = 0, beats = 0;
    int last_act = -100, last_rd = -100;
    logic prev_ready = 1'b0;
    bit mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_on) begin
            if (cmd != 4'b0111 && cmd != 4'b0011 && cmd != 4'b0101)
                chk(0, "R1", "illegal command", cmd, 4'b0111);
            if (cmd == 4'b0011) begin
                chk(sd_addr == ex_row[act_n], "R2", "ACTIVE row", sd_addr, ex_row[act_n]);
                chk(sd_ba == ex_bank[act_n], "R2", "ACTIVE bank", sd_ba, ex_bank[act_n]);
                chk(!req_ready, "R7", "ready in ACTIVE cycle", req_ready, 0);
                chk(sd_dqm == 2'b11, "R9", "masks at ACTIVE", sd_dqm, 2'b11);
                if (act_n > 0) begin
                    chk(cyc - last_act >= GAP, "R6", "ACTIVE spacing", cyc - last_act, GAP);
                    if (ex_held[act_n])
                        chk(cyc - last_act == GAP, "R10", "held request spacing", cyc - last_act, GAP);
                end
                last_act = cyc;
                act_n++;
            end
            if (cmd == 4'b0101) begin
                chk(cyc - last_act == RCD, "R3", "READ after ACTIVE", cyc - last_act, RCD);
                chk(sd_addr == {1'b1, 2'b00, ex_col[act_n-1]}, "R4", "READ address",
                    sd_addr, {1'b1, 2'b00, ex_col[act_n-1]});
                chk(sd_dqm == 2'b00, "R9", "masks at READ", sd_dqm, 2'b00);
                last_rd = cyc;
                rd_n++;
            end
            if (rd_valid) begin : vbeat
                logic [7:0] c;
                c = ex_col[rd_n-1];
                c = {c[7:2], 2'(c[1:0] + 2'(beat))};
                chk(cyc == last_rd + FIRST + beat, "R5", "beat cycle", cyc, last_rd + FIRST + beat);
                chk(rd_data == pat(ex_bank[rd_n-1], ex_row[rd_n-1], c), "R5", "beat data",
                    rd_data, pat(ex_bank[rd_n-1], ex_row[rd_n-1], c));
                chk(rd_last == (beat == BLEN - 1), "R8", "last flag", rd_last, beat == BLEN - 1);
                beat = (beat + 1) % BLEN;
                beats++;
            end
            if (req_ready && !prev_ready && act_n > 0)
                chk(cyc - last_act == RDY, "R7", "ready return", cyc - last_act, RDY);
        end
        prev_ready = req_ready;
    end

    task automatic send(input logic [23:0] v);
        for (int g = 0; g < int'(v[23:20]); g++) @(negedge clk);
        ex_bank[n_sent] = v[19];
        ex_row[n_sent]  = v[18:8];
        ex_col[n_sent]  = v[7:0];
        ex_held[n_sent] = (v[23:20] == 0) && (n_sent > 0);
        n_sent++;
        req_bank = v[19]; req_row = v[18:8]; req_col = v[7:0];
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state, R1
        chk(cmd == 4'b0111, "R1", "reset command", cmd, 4'b0111);
        chk(req_ready, "R1", "reset ready", req_ready, 1);
        chk(!rd_valid, "R1", "reset valid", rd_valid, 0);
        chk(sd_dqm == 2'b11, "R1", "reset masks", sd_dqm, 2'b11);
        mon_on = 1'b1;
        // No request: NOP only, R1
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(cmd == 4'b0111 && !rd_valid, "R1", "idle NOP", cmd, 4'b0111);
        end
        for (int i = 0; i < NV; i++) send(VEC[i]);
        repeat (30) @(negedge clk);
        chk(act_n == NV, "R10", "requests accepted", act_n, NV);
        chk(rd_n == NV, "R3", "READ count", rd_n, NV);
        chk(beats == NV * BLEN, "R8", "beat count", beats, NV * BLEN);
        chk(sd_dqm == 2'b11 && req_ready, "R9", "masks after burst", sd_dqm, 2'b11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule